// File: doc/BRIEF.md
# Three-Wire Serial Memory Read Slave

This block is the slave end of a three-wire serial memory that holds 64 words of 16 bits. The pins are a select, a serial clock and a serial data input, plus a serial data output with an enable for a tri-state pad. All three inputs are synchronised into the system clock domain. A rising edge of the serial clock is detected there. Each instruction starts with a start bit, then a 2-bit opcode, then a 6-bit address.

A read instruction drives one dummy bit and then streams words. Each word goes out most significant bit first. The word pointer steps forward after every word and wraps from the top word back to word 0. The stream continues for as long as select stays high, so the whole array can be read in one instruction. The storage is a register array inside the block. A separate write sequencer loads the array through a plain single-cycle write port.

Write-class instructions are decoded only as far as the opcode and address. They are then offered to that sequencer on a valid/ready command channel. A command stays on the channel until it is accepted. Back-pressure is never stored: there is one command slot. A write-class instruction that completes while the slot is still full is dropped. The slot frees in the same cycle that `cmd_ready` accepts the command.

Top module: `mw_read_slave`

## Requirements
- R1: While select is high, zeros on `sdi` before the first 1 are ignored, and that first 1 is the start bit. The start bit is followed by a 2-bit opcode and then a 6-bit address, both most significant bit first. Every bit is sampled on a rising edge of `sclk`.
- R2: With opcode 10 (read), the rising edge that samples the last address bit sets `sdo_en` high and `sdo` to a dummy 0.
- R3: Each later rising `sclk` edge drives the next bit of the addressed word on `sdo`, starting at bit 15 and ending at bit 0.
- R4: After bit 0 of a word, the next rising edge drives bit 15 of the word at the next address. There is no gap and no new instruction.
- R5: The word after address 63 is address 0, and the stream carries on.
- R6: `sdo_en` is low after reset, and low while select is low once SYNC_STAGES+2 clock cycles have passed. It is also low while an instruction is still being shifted in.
- R7: Pulling select low in the middle of an instruction abandons it. The next instruction is parsed from its start bit.
- R8: Opcodes 01 (write), 11 (page write) and 00 (write-all and protect group, picked by the address bits) put the opcode and address on `cmd_op`/`cmd_addr` with `cmd_valid` high. `sdo_en` stays low, and later `sdi` bits are ignored until select goes low.
- R9: `cmd_valid` holds high with a stable `cmd_op`/`cmd_addr` until a cycle with `cmd_ready` high. A write-class instruction that completes while the slot is full and not being accepted is dropped.
- R10: A clock cycle with `mem_we` high stores `mem_wdata` at `mem_waddr`, and later reads return the stored word.
- R11: During a read, `sdo` changes only after a sampled rising `sclk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Serial select, active high |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for the `sdo` pad; low means high impedance |
| mem_we | input | 1 | Array write strobe from the write sequencer |
| mem_waddr | input | 6 | Array write address |
| mem_wdata | input | 16 | Array write data |
| cmd_valid | output | 1 | A write-class command is offered |
| cmd_ready | input | 1 | The write sequencer accepts the command |
| cmd_op | output | 2 | Opcode of the offered command |
| cmd_addr | output | 6 | Address field of the offered command |

## Verification
A wrong bit counter or a wrong parser state shows up within a single serial clock period. The dummy bit appears one edge early or late, or a word comes out rotated, and the very first word read gives it away. A pointer that loads or steps wrongly returns a word from the wrong address at the next word boundary. This is most visible on a stream that crosses address 63. A command slot that loses its state shows up at the ports within one clock of the event: `cmd_valid` drops without an accept, or its payload changes while it is waiting.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [1:0] {
    PS_HUNT,
    PS_OPC,
    PS_ADDR,
    PS_DONE
  } parse_st_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_PAGE  = 2'b11;
  localparam logic [1:0] OP_EXT   = 2'b00;

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] d_out
);

  logic [N-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign d_out = chain[STAGES-1];

endmodule

// File: rtl/mw_frame_parser.sv
module mw_frame_parser
  import mw_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_s,
  input  logic          sclk_rise,
  input  logic          sdi_s,
  output logic          rd_go,
  output logic          cmd_go,
  output logic [1:0]    op_full,
  output logic [AW-1:0] addr_full
);

  localparam int CW = $clog2(AW) + 1;

  parse_st_e     state;
  logic [CW-1:0] cnt;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic          last_bit;

  assign last_bit  = sel_s && sclk_rise && (state == PS_ADDR) && (cnt == CW'(AW - 1));
  assign addr_full = {addr_q[AW-2:0], sdi_s};
  assign op_full   = op_q;
  assign rd_go     = last_bit && (op_q == OP_READ);
  assign cmd_go    = last_bit && (op_q != OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PS_HUNT;
      cnt    <= '0;
      op_q   <= '0;
      addr_q <= '0;
    end else if (!sel_s) begin
      state <= PS_HUNT;
      cnt   <= '0;
    end else if (sclk_rise) begin
      case (state)
        PS_HUNT: begin
          if (sdi_s) begin
            state <= PS_OPC;
            cnt   <= '0;
          end
        end
        PS_OPC: begin
          op_q <= {op_q[0], sdi_s};
          if (cnt == CW'(1)) begin
            state <= PS_ADDR;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        PS_ADDR: begin
          addr_q <= addr_full;
          if (cnt == CW'(AW - 1)) begin
            state <= PS_DONE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: state <= PS_DONE;
      endcase
    end
  end

endmodule

// File: rtl/mw_read_streamer.sv
module mw_read_streamer #(
  parameter int WORDS = 64,
  parameter int WIDTH = 16,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_s,
  input  logic             sclk_rise,
  input  logic             rd_go,
  input  logic [AW-1:0]    rd_addr,
  input  logic [WIDTH-1:0] rd_word,
  output logic [AW-1:0]    rd_ptr,
  output logic             rd_active,
  output logic             sdo_bit
);

  localparam int BW = $clog2(WIDTH);

  logic [WIDTH-1:0] sh;
  logic [BW-1:0]    bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_active <= 1'b0;
      rd_ptr    <= '0;
      sh        <= '0;
      bcnt      <= '0;
      sdo_bit   <= 1'b0;
    end else if (!sel_s) begin
      rd_active <= 1'b0;
    end else if (rd_go) begin
      rd_active <= 1'b1;
      rd_ptr    <= rd_addr;
      bcnt      <= '0;
      sdo_bit   <= 1'b0;
    end else if (rd_active && sclk_rise) begin
      if (bcnt == '0) begin
        sdo_bit <= rd_word[WIDTH-1];
        sh      <= {rd_word[WIDTH-2:0], 1'b0};
        rd_ptr  <= (rd_ptr == AW'(WORDS - 1)) ? '0 : rd_ptr + AW'(1);
      end else begin
        sdo_bit <= sh[WIDTH-1];
        sh      <= {sh[WIDTH-2:0], 1'b0};
      end
      bcnt <= (bcnt == BW'(WIDTH - 1)) ? '0 : bcnt + BW'(1);
    end
  end

endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
  parameter int WORDS = 64,
  parameter int WIDTH = 16,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         mem[i] <= '0;
      else if (we && waddr == AW'(i))     mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/mw_cmd_handoff.sv
module mw_cmd_handoff #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [1:0]    op_in,
  input  logic [AW-1:0] addr_in,
  output logic          valid,
  input  logic          ready,
  output logic [1:0]    op,
  output logic [AW-1:0] addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      op    <= '0;
      addr  <= '0;
    end else if (go && (!valid || ready)) begin
      valid <= 1'b1;
      op    <= op_in;
      addr  <= addr_in;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/mw_read_slave.sv
module mw_read_slave #(
  parameter int WORDS       = 64,
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             sclk,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_en,
  input  logic             mem_we,
  input  logic [AW-1:0]    mem_waddr,
  input  logic [WIDTH-1:0] mem_wdata,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_op,
  output logic [AW-1:0]    cmd_addr
);

  logic             sel_s, sclk_s, sdi_s, sclk_q, sclk_rise;
  logic             rd_go, cmd_go, rd_active, sdo_bit;
  logic [1:0]       op_full;
  logic [AW-1:0]    addr_full, rd_ptr;
  logic [WIDTH-1:0] rd_word;

  mw_pin_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({sel, sclk, sdi}),
    .d_out ({sel_s, sclk_s, sdi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  assign sclk_rise = sel_s && sclk_s && !sclk_q;

  mw_frame_parser #(.AW(AW)) u_parse (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_s     (sel_s),
    .sclk_rise (sclk_rise),
    .sdi_s     (sdi_s),
    .rd_go     (rd_go),
    .cmd_go    (cmd_go),
    .op_full   (op_full),
    .addr_full (addr_full)
  );

  mw_word_array #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (rd_ptr),
    .rdata (rd_word)
  );

  mw_read_streamer #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW)) u_stream (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_s     (sel_s),
    .sclk_rise (sclk_rise),
    .rd_go     (rd_go),
    .rd_addr   (addr_full),
    .rd_word   (rd_word),
    .rd_ptr    (rd_ptr),
    .rd_active (rd_active),
    .sdo_bit   (sdo_bit)
  );

  mw_cmd_handoff #(.AW(AW)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (cmd_go),
    .op_in   (op_full),
    .addr_in (addr_full),
    .valid   (cmd_valid),
    .ready   (cmd_ready),
    .op      (cmd_op),
    .addr    (cmd_addr)
  );

  assign sdo    = sdo_bit;
  assign sdo_en = sel_s && rd_active;

endmodule

// File: rtl/mw_read_slave_chk.sv
module mw_read_slave_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sclk_rise,
  input logic          sdo,
  input logic          rd_active,
  input logic [AW-1:0] rd_ptr,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [AW-1:0] cmd_addr
);

  // R2: a read stream opens with a dummy 0, on a serial clock edge
  assert_dummy_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_active) |-> (sdo == 1'b0) && $past(sclk_rise));

  // R11: data out holds between sampled serial clock edges
  assert_sdo_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && $past(rd_active) && !$past(sclk_rise)) |-> $stable(sdo));

  // R4 and R5: the pointer only steps by one, modulo the array size
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && $past(rd_active) && !$stable(rd_ptr)) |->
      (rd_ptr == AW'($past(rd_ptr) + AW'(1))));

  // R9: an offered command waits unchanged until accepted
  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr));

  // R8: reads are never offered to the write sequencer
  assert_no_read_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op != 2'b10));

endmodule

bind mw_read_slave mw_read_slave_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk_rise (sclk_rise),
  .sdo       (sdo),
  .rd_active (rd_active),
  .rd_ptr    (rd_ptr),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_addr  (cmd_addr)
);

// File: tb/mw_read_slave_tb.sv
module mw_read_slave_tb;

  localparam int HALF  = 8;
  localparam int SYNC  = 2;
  localparam int NVEC  = 6;
  // vector fields: start address [15:10], leading zeros [9:7], word count [6:0]
  localparam logic [15:0] VEC [NVEC] = '{
    {6'd0,  3'd0, 7'd1},
    {6'd17, 3'd2, 7'd2},
    {6'd62, 3'd1, 7'd4},
    {6'd63, 3'd0, 7'd2},
    {6'd31, 3'd5, 7'd3},
    {6'd0,  3'd3, 7'd65}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic        sdo, sdo_en;
  logic        mem_we = 1'b0;
  logic [5:0]  mem_waddr = '0;
  logic [15:0] mem_wdata = '0;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [1:0]  cmd_op;
  logic [5:0]  cmd_addr;

  logic [15:0] model [64];
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mw_read_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr)
  );

  function automatic logic [15:0] pat(int i);
    return 16'(i * 40503) ^ 16'hC3A5;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    @(negedge clk) sdi = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic deselect();
    @(negedge clk) sel = 1'b0;
    repeat (SYNC + 3) @(negedge clk);
    check(sdo_en == 1'b0, "R6 enable low after deselect", {31'd0, sdo_en}, 32'd0);
  endtask

  task automatic do_read(input logic [5:0] addr, input int lead, input int n);
    logic [15:0] got;
    @(negedge clk) sel = 1'b1;
    repeat (4) @(negedge clk);
    for (int z = 0; z < lead; z++) pulse(1'b0);  // R1 leading zeros
    pulse(1'b1);
    pulse(1'b1);
    pulse(1'b0);
    for (int b = 5; b >= 0; b--) begin
      pulse(addr[b]);
      if (b == 1)
        check(sdo_en == 1'b0, "R6 enable low during instruction", {31'd0, sdo_en}, 32'd0);
    end
    check(sdo_en && sdo == 1'b0, "R2 dummy bit", {30'd0, sdo_en, sdo}, 32'd2);
    for (int w = 0; w < n; w++) begin
      got = '0;
      for (int b = 0; b < 16; b++) begin
        pulse(1'b0);
        got = {got[14:0], sdo};
      end
      if (w == 0)
        check(got == model[addr], "R3 R1 first word", {16'd0, got}, {16'd0, model[addr]});
      else if (32'(addr) + 32'(w) >= 64)
        check(got == model[6'(addr + 6'(w))], "R5 wrapped word", {16'd0, got}, {16'd0, model[6'(addr + 6'(w))]});
      else
        check(got == model[6'(addr + 6'(w))], "R4 next word", {16'd0, got}, {16'd0, model[6'(addr + 6'(w))]});
    end
    got[0] = sdo;
    repeat (20) @(negedge clk);
    check(sdo == got[0], "R11 sdo holds without sclk edge", {31'd0, sdo}, {31'd0, got[0]});
    deselect();
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [5:0] addr, input int ndata);
    @(negedge clk) sel = 1'b1;
    repeat (4) @(negedge clk);
    pulse(1'b1);
    pulse(op[1]);
    pulse(op[0]);
    for (int b = 5; b >= 0; b--) pulse(addr[b]);
    for (int d = 0; d < ndata; d++) pulse(d[0]);
    check(sdo_en == 1'b0, "R8 no output for write class", {31'd0, sdo_en}, 32'd0);
    deselect();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sdo_en == 1'b0, "R6 reset enable", {31'd0, sdo_en}, 32'd0);
    check(cmd_valid == 1'b0, "R9 reset valid", {31'd0, cmd_valid}, 32'd0);

    // R10 load the array through the write port
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      mem_we = 1'b1; mem_waddr = 6'(i); mem_wdata = pat(i);
      model[i] = pat(i);
    end
    @(negedge clk) mem_we = 1'b0;

    for (int v = 0; v < NVEC; v++)
      do_read(VEC[v][15:10], int'(VEC[v][9:7]), int'(VEC[v][6:0]));

    // R10 overwrite one word and read it back
    @(negedge clk);
    mem_we = 1'b1; mem_waddr = 6'd10; mem_wdata = 16'hBEEF;
    @(negedge clk) mem_we = 1'b0;
    model[10] = 16'hBEEF;
    do_read(6'd10, 0, 1);
    check(model[10] == 16'hBEEF, "R10 model", {16'd0, model[10]}, 32'h0000BEEF);

    // R8 R9 write command with back-pressure, data bits ignored
    send_cmd(2'b01, 6'd9, 16);
    check(cmd_valid && cmd_op == 2'b01 && cmd_addr == 6'd9, "R8 write command",
          {23'd0, cmd_valid, cmd_op, cmd_addr}, {23'd0, 1'b1, 2'b01, 6'd9});
    send_cmd(2'b11, 6'd40, 4);
    check(cmd_valid && cmd_op == 2'b01 && cmd_addr == 6'd9, "R9 held while pending",
          {23'd0, cmd_valid, cmd_op, cmd_addr}, {23'd0, 1'b1, 2'b01, 6'd9});
    @(negedge clk) cmd_ready = 1'b1;
    @(negedge clk) cmd_ready = 1'b0;
    @(negedge clk);
    check(cmd_valid == 1'b0, "R9 second command dropped", {31'd0, cmd_valid}, 32'd0);

    send_cmd(2'b00, 6'b010011, 0);
    check(cmd_valid && cmd_op == 2'b00 && cmd_addr == 6'b010011, "R8 extended command",
          {23'd0, cmd_valid, cmd_op, cmd_addr}, {23'd0, 1'b1, 2'b00, 6'b010011});
    @(negedge clk) cmd_ready = 1'b1;
    @(negedge clk) cmd_ready = 1'b0;
    @(negedge clk);
    check(cmd_valid == 1'b0, "R9 accepted", {31'd0, cmd_valid}, 32'd0);

    // R7 abort a read halfway through its address, then read again
    @(negedge clk) sel = 1'b1;
    repeat (4) @(negedge clk);
    pulse(1'b1); pulse(1'b1); pulse(1'b0); pulse(1'b1); pulse(1'b1);
    deselect();
    do_read(6'd5, 0, 2);
    check(cmd_valid == 1'b0, "R7 abort leaves no command", {31'd0, cmd_valid}, 32'd0);

    finished = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule